// File: doc/BRIEF.md
# Panel AUX Power Sequencer

This block decides when the auxiliary channel of a display output is held permanently awake ("always-on") and when it is only woken for transfers ("on-demand"). It follows a level request. When the request moves to always-on and the output is an embedded panel, the block looks at the sensed panel-supply GPIO. It switches the supply on only if nobody else has, and it records that it did so. It then waits a fixed settle time before it enables continuous AUX monitoring. The settle time applies whether or not the panel was already powered.

When the request moves back to on-demand, monitoring is switched off first. On the next cycle the panel supply is switched off, but only if this block was the one that switched it on. A ready flag is low while a sequence is running. Any change of the request during that time waits until the sequence ends.

Top module: `panel_aux_pwr_seq`

## Requirements
- R1: After reset the block is in on-demand mode: `aux_monitor_en`=0, `panel_pwr_oe`=0, `panel_pwr_drive`=0 and `aux_ready`=1.
- R2: When `aux_ready`=1 and `aux_always_req` equals the current mode (1 = always-on, shown on `aux_monitor_en`), no output changes.
- R3: An always-on request for an embedded output (`is_embedded`=1) while `panel_pwr_sense`=0 sets `panel_pwr_oe`=1 and `panel_pwr_drive`=1 at the edge that accepts the request.
- R4: An always-on request for an embedded output while `panel_pwr_sense`=1 leaves `panel_pwr_oe` and `panel_pwr_drive` unchanged.
- R5: For an embedded output, `aux_monitor_en` rises exactly `SETTLE_CYCLES` clock edges after the accepting edge, whatever the sensed level was.
- R6: `aux_ready` is 0 from the accepting edge of an embedded always-on request until the edge where `aux_monitor_en` rises, and it returns to 1 at that edge.
- R7: For a non-embedded output, an always-on request raises `aux_monitor_en` at the accepting edge, keeps `aux_ready`=1 and leaves the GPIO outputs unchanged.
- R8: An on-demand request in always-on mode clears `aux_monitor_en` at the accepting edge while the GPIO is unchanged and `aux_ready`=0. At the next edge `panel_pwr_drive` goes to 0 only if this block raised it, that ownership is cleared, and `aux_ready` returns to 1.
- R9: A change of `aux_always_req` during the settle wait does not shorten it. The always-on sequence completes first, and the new level is acted on at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_always_req | input | 1 | Requested AUX power mode: 1 always-on, 0 on-demand |
| is_embedded | input | 1 | Output is an embedded panel connector |
| panel_pwr_sense | input | 1 | Sensed level of the panel-supply GPIO |
| panel_pwr_drive | output | 1 | Level driven on the panel-supply GPIO |
| panel_pwr_oe | output | 1 | Output enable of the panel-supply GPIO (0 = released) |
| aux_monitor_en | output | 1 | Continuous AUX monitoring enable |
| aux_ready | output | 1 | No sequence in progress |

## Verification
Two things can land on the same edge: the settle wait expiring, and a withdrawal of the always-on request. The bench drops the request at several points in the wait, including the negative edge just before expiry, so the withdrawal is sampled on the expiry edge itself. It then expects monitoring to come on at that edge and to go off one edge later. The sweep covers every combination of connector type, sensed supply level and prior supply ownership. The bench judges each result against a model of ownership that it keeps itself.

// File: rtl/pnl_aux_pkg.sv
package pnl_aux_pkg;

    typedef enum logic [1:0] {
        MODE_DEMAND  = 2'd0,
        MODE_SETTLE  = 2'd1,
        MODE_ALWAYS  = 2'd2,
        MODE_RELEASE = 2'd3
    } aux_mode_e;

    typedef struct packed {
        aux_mode_e mode;
        logic      mon_en;
    } seq_state_t;

    typedef struct packed {
        logic drive;
        logic oe;
        logic owned;
    } pwr_own_t;

endpackage

// File: rtl/pnl_settle_timer.sv
module pnl_settle_timer #(
    parameter int unsigned CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pnl_pwr_owner.sv
module pnl_pwr_owner
    import pnl_aux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic drop,
    output logic drive,
    output logic oe,
    output logic owned
);
    pwr_own_t own_d, own_q;

    always_comb begin
        own_d = own_q;
        if (take) begin
            own_d.drive = 1'b1;
            own_d.oe    = 1'b1;
            own_d.owned = 1'b1;
        end else if (drop) begin
            own_d.drive = 1'b0;
            own_d.owned = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '0;
        end else begin
            own_q <= own_d;
        end
    end

    assign drive = own_q.drive;
    assign oe    = own_q.oe;
    assign owned = own_q.owned;
endmodule

// File: rtl/panel_aux_pwr_seq.sv
module panel_aux_pwr_seq
    import pnl_aux_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_always_req,
    input  logic is_embedded,
    input  logic panel_pwr_sense,
    output logic panel_pwr_drive,
    output logic panel_pwr_oe,
    output logic aux_monitor_en,
    output logic aux_ready
);
    seq_state_t st_d, st_q;
    logic take_pwr, drop_pwr, tmr_start, tmr_expired, we_own;

    always_comb begin
        st_d      = st_q;
        take_pwr  = 1'b0;
        drop_pwr  = 1'b0;
        tmr_start = 1'b0;
        unique case (st_q.mode)
            MODE_DEMAND: begin
                if (aux_always_req) begin
                    if (is_embedded) begin
                        take_pwr  = !panel_pwr_sense;
                        tmr_start = 1'b1;
                        st_d.mode = MODE_SETTLE;
                    end else begin
                        st_d.mode   = MODE_ALWAYS;
                        st_d.mon_en = 1'b1;
                    end
                end
            end
            MODE_SETTLE: begin
                if (tmr_expired) begin
                    st_d.mode   = MODE_ALWAYS;
                    st_d.mon_en = 1'b1;
                end
            end
            MODE_ALWAYS: begin
                if (!aux_always_req) begin
                    st_d.mode   = MODE_RELEASE;
                    st_d.mon_en = 1'b0;
                end
            end
            MODE_RELEASE: begin
                drop_pwr  = we_own;
                st_d.mode = MODE_DEMAND;
            end
            default: begin
                st_d.mode   = MODE_DEMAND;
                st_d.mon_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_DEMAND;
            st_q.mon_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pnl_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    pnl_pwr_owner u_owner (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take_pwr),
        .drop  (drop_pwr),
        .drive (panel_pwr_drive),
        .oe    (panel_pwr_oe),
        .owned (we_own)
    );

    assign aux_monitor_en = st_q.mon_en;
    assign aux_ready      = (st_q.mode == MODE_DEMAND) || (st_q.mode == MODE_ALWAYS);
endmodule

// File: rtl/panel_aux_pwr_seq_chk.sv
module panel_aux_pwr_seq_chk #(
    parameter int unsigned SETTLE_CYCLES = 30_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic aux_always_req,
    input logic is_embedded,
    input logic panel_pwr_sense,
    input logic panel_pwr_drive,
    input logic panel_pwr_oe,
    input logic aux_monitor_en,
    input logic aux_ready
);
    localparam int unsigned WW = $clog2(SETTLE_CYCLES + 2);

    logic [WW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (aux_ready || aux_monitor_en) begin
            wait_cnt <= '0;
        end else if (wait_cnt != '1) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    a_r2_same_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_ready && (aux_always_req == aux_monitor_en)) |=>
            ($stable(aux_monitor_en) && $stable(panel_pwr_drive) && $stable(panel_pwr_oe) && aux_ready));

    a_r3_power_only_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_pwr_drive) |-> ($past(!panel_pwr_sense) && $past(is_embedded) && $past(aux_always_req)));

    a_r4_sensed_high_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_always_req && is_embedded && panel_pwr_sense && aux_ready && !aux_monitor_en) |=>
            ($stable(panel_pwr_drive) && $stable(panel_pwr_oe)));

    a_r5_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(aux_monitor_en) && $past(!aux_ready)) |-> (wait_cnt == WW'(SETTLE_CYCLES)));

    a_r6_ready_with_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_monitor_en) |-> aux_ready);

    a_r7_direct_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(aux_monitor_en) && $past(aux_ready)) |->
            ($past(!is_embedded) && $stable(panel_pwr_drive) && $stable(panel_pwr_oe)));

    a_r8_monitor_off_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aux_monitor_en) |-> ($stable(panel_pwr_drive) && !aux_ready));

    a_r8_gpio_after_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_pwr_drive) |-> ($past(aux_monitor_en, 2) && !$past(aux_monitor_en) && aux_ready));
endmodule

bind panel_aux_pwr_seq panel_aux_pwr_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .aux_always_req  (aux_always_req),
    .is_embedded     (is_embedded),
    .panel_pwr_sense (panel_pwr_sense),
    .panel_pwr_drive (panel_pwr_drive),
    .panel_pwr_oe    (panel_pwr_oe),
    .aux_monitor_en  (aux_monitor_en),
    .aux_ready       (aux_ready)
);

// File: tb/panel_aux_pwr_seq_test.sv
module panel_aux_pwr_seq_test;
    localparam int unsigned S = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic emb = 1'b0;
    logic sns = 1'b0;
    logic drv, oe, mon, rdy;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_drv = 1'b0;
    logic exp_oe = 1'b0;
    logic owned = 1'b0;

    always #2.5 clk = ~clk;

    panel_aux_pwr_seq #(.SETTLE_CYCLES(S)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .aux_always_req  (req),
        .is_embedded     (emb),
        .panel_pwr_sense (sns),
        .panel_pwr_drive (drv),
        .panel_pwr_oe    (oe),
        .aux_monitor_en  (mon),
        .aux_ready       (rdy)
    );

    task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {drive,oe,mon,ready} actual %b expected %b at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] outs();
        return {drv, oe, mon, rdy};
    endfunction

    // Always-on request; drop_at > 0 withdraws it before settle edge drop_at (R9)
    task automatic go_on(input logic e, input logic s, input int drop_at);
        @(negedge clk);
        emb = e; sns = s; req = 1'b1;
        @(posedge clk);
        if (e && !s) begin
            exp_drv = 1'b1; exp_oe = 1'b1; owned = 1'b1;
        end
        @(negedge clk);
        if (!e) begin
            chk("R7 direct enable", outs(), {exp_drv, exp_oe, 2'b11});
        end else begin
            chk(s ? "R4 sensed high untouched" : "R3 power on when low", outs(), {exp_drv, exp_oe, 2'b00});
            for (int k = 1; k < S; k++) begin
                if (k == drop_at) req = 1'b0;
                @(posedge clk);
                @(negedge clk);
                chk("R6 busy during settle", outs(), {exp_drv, exp_oe, 2'b00});
            end
            if (drop_at == S) req = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk("R5 enable after settle", outs(), {exp_drv, exp_oe, 2'b11});
        end
    endtask

    task automatic go_off(input logic already_dropped);
        @(negedge clk);
        req = 1'b0;
        if (!already_dropped) @(posedge clk);
        if (already_dropped) @(posedge clk);
        @(negedge clk);
        chk("R8 monitor off first", outs(), {exp_drv, exp_oe, 2'b00});
        @(posedge clk);
        if (owned) begin
            exp_drv = 1'b0; owned = 1'b0;
        end
        @(negedge clk);
        chk("R8 gpio restore", outs(), {exp_drv, exp_oe, 2'b01});
    endtask

    task automatic hold(input string rq, input logic level);
        @(negedge clk);
        req = level;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(rq, outs(), {exp_drv, exp_oe, level, 1'b1});
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", outs(), 4'b0001);
        rst_n = 1'b1;
        hold("R2 repeated on-demand", 1'b0);
        for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int rep = 0; rep < 2; rep++) begin
                    go_on(e[0], s[0], 0);
                    hold("R2 repeated always-on", 1'b1);
                    go_off(1'b0);
                    hold("R2 repeated on-demand", 1'b0);
                end
            end
        end
        // R9: withdrawal at several points, including the expiry edge itself
        for (int s = 0; s < 2; s++) begin
            for (int d = 1; d <= S; d++) begin
                go_on(1'b1, s[0], d);
                // request already low: release happens at the next edge
                @(posedge clk);
                if (1'b1) begin
                    @(negedge clk);
                    chk("R9 held request released", outs(), {exp_drv, exp_oe, 2'b00});
                    @(posedge clk);
                    if (owned) begin
                        exp_drv = 1'b0; owned = 1'b0;
                    end
                    @(negedge clk);
                    chk("R9 R8 restore after held release", outs(), {exp_drv, exp_oe, 2'b01});
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule